// File: doc/BRIEF.md
# DDR Command Decoder and Protocol Checker

This block watches the command pins of a DDR SDRAM bus and names the command on every rising clock edge. It keeps one cycle of clock-enable history, so it can tell refresh from self-refresh entry and spot power-down entry and exit. It uses the bank-address and A10 pins to choose the target bank, to mark auto-precharge on reads and writes, and to pick between single-bank and all-bank precharge. Pin combinations with no defined meaning decode as NOP.

Alongside the decode, the block tracks which banks hold an open row and whether a mode-register write was just issued. It raises a one-cycle error flag when a command breaks an ordering rule. A mode-register write or a refresh is issued while a bank is open, or a command arrives inside the lockout that follows a mode-register write. It is meant as a passive monitor beside a memory controller, or in a bus-level testbench. The flagged command is still reported and still acts on the tracked state.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: While reset is held and in the cycle after it is released, cmd_o is 0 (NOP), bank_o is 0 and err_o is 0. After reset the clock-enable history reads high, no bank is open and no lockout is active.
- R2: Pins sampled at a rising edge are reported on cmd_o, bank_o and err_o from that edge until the next one. With CKE high in both cycles, cs_n_i high (deselect) or RAS#, CAS# and WE# all high decodes as 0 (NOP).
- R3: With CKE high in both cycles and CS#, RAS#, CAS# and WE# all low, the code is 1 (mode register set) when ba_i[0] is 0 and 2 (extended mode register set) when ba_i[0] is 1.
- R4: With CS#, RAS# and CAS# low and WE# high, the code is 3 (auto refresh) when CKE stays high and 4 (self-refresh entry) when CKE goes from high to low.
- R5: With CKE high in both cycles and CS# low, the codes are 6 for activate (RAS# low, CAS# and WE# high), 7 for read (CAS# low, RAS# and WE# high), 9 for write (CAS# and WE# low, RAS# high), 11 for burst stop (WE# low, RAS# and CAS# high) and 12 for precharge (RAS# and WE# low, CAS# high). For activate, read, write and single-bank precharge, bank_o is {ba_i[1], ba_i[0]}, so 0..3 are banks A..D.
- R6: A read or write with a10_i high reports 8 (read with auto-precharge) or 10 (write with auto-precharge) in place of 7 or 9.
- R7: A precharge with a10_i high reports 13 (precharge all) and bank_o is 0 whatever ba_i holds.
- R8: When CKE falls with deselect or NOP pins, the code is 14 (power-down entry). When CKE falls with any other pins except refresh, the code is 0. When CKE stays low, the code is 0 whatever the pins are. When CKE rises, the code is 5 (self-refresh exit) if a self-refresh entry came before it, and 15 (power-down exit) otherwise.
- R9: An activate opens its bank. Precharge, precharge-all, and read or write with auto-precharge close the addressed banks. A code 1 or 2 issued while any bank is open raises err_o.
- R10: A code 3 or 4 issued while any bank is open raises err_o.
- R11: After a code 1 or 2, any code other than 0 in the next MRD_CYCLES-1 cycles raises err_o. With the default of 2, a command exactly two cycles after the mode-register write is accepted.
- R12: err_o is high only in the cycle that reports the offending command. That command's code and bank are still reported, and it still updates the bank and lockout state.
- R13: bank_o is 0 for every code other than 6, 7, 8, 9, 10 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable, current level |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Address bit 10 (auto-precharge / all banks) |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Target bank of the decoded command |
| err_o | output | 1 | One-cycle ordering-rule violation flag |

## Verification
Error detection and bank-state updates can land in the same cycle. An activate issued inside the mode-register lockout is flagged, but it still opens its bank. The bench provokes this directly: it issues an extended mode register set, then an activate on the very next cycle, then a mode register set one cycle later. It expects an error on the activate, and a second error on the mode register set because the flagged activate left a bank open. Random traffic then mixes lockout windows, open banks and clock-enable transitions. A bench model built from the requirements predicts code, bank and error for every cycle.

// File: rtl/ddrcmd_pkg.sv
package ddrcmd_pkg;

    localparam int BANK_W = 2;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_MRS      = 4'd1,
        CMD_EMRS     = 4'd2,
        CMD_AREF     = 4'd3,
        CMD_SREF_IN  = 4'd4,
        CMD_SREF_OUT = 4'd5,
        CMD_ACT      = 4'd6,
        CMD_RD       = 4'd7,
        CMD_RDA      = 4'd8,
        CMD_WR       = 4'd9,
        CMD_WRA      = 4'd10,
        CMD_BST      = 4'd11,
        CMD_PRE      = 4'd12,
        CMD_PREA     = 4'd13,
        CMD_PD_IN    = 4'd14,
        CMD_PD_OUT   = 4'd15
    } cmd_e;

    typedef struct packed {
        logic              cke;
        logic              cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BANK_W-1:0] ba;
        logic              a10;
    } pins_t;

    typedef struct packed {
        cmd_e              code;
        logic [BANK_W-1:0] bank;
    } dec_t;

    // Mode-register writes: both need every bank idle.
    function automatic logic is_mode_write(cmd_e c);
        return (c == CMD_MRS) || (c == CMD_EMRS);
    endfunction

    function automatic logic is_refresh(cmd_e c);
        return (c == CMD_AREF) || (c == CMD_SREF_IN);
    endfunction

    // Commands after which the addressed bank has no open row.
    function automatic logic closes_bank(cmd_e c);
        return (c == CMD_PRE) || (c == CMD_RDA) || (c == CMD_WRA);
    endfunction

endpackage

// File: rtl/ddr_cmd_classify.sv
module ddr_cmd_classify
    import ddrcmd_pkg::*;
(
    input  pins_t pins_i,
    input  logic  cke_prev_i,
    input  logic  in_sref_i,
    output dec_t  dec_o
);

    logic quiet_pins;

    always_comb begin
        quiet_pins  = pins_i.cs_n | (pins_i.ras_n & pins_i.cas_n & pins_i.we_n);
        dec_o.code  = CMD_NOP;
        dec_o.bank  = '0;
        unique case ({cke_prev_i, pins_i.cke})
            2'b11: begin
                if (!pins_i.cs_n) begin
                    unique case ({pins_i.ras_n, pins_i.cas_n, pins_i.we_n})
                        3'b000: dec_o.code = pins_i.ba[0] ? CMD_EMRS : CMD_MRS;
                        3'b001: dec_o.code = CMD_AREF;
                        3'b011: begin
                            dec_o.code = CMD_ACT;
                            dec_o.bank = pins_i.ba;
                        end
                        3'b101: begin
                            dec_o.code = pins_i.a10 ? CMD_RDA : CMD_RD;
                            dec_o.bank = pins_i.ba;
                        end
                        3'b100: begin
                            dec_o.code = pins_i.a10 ? CMD_WRA : CMD_WR;
                            dec_o.bank = pins_i.ba;
                        end
                        3'b110: dec_o.code = CMD_BST;
                        3'b010: begin
                            if (pins_i.a10) begin
                                dec_o.code = CMD_PREA;
                            end else begin
                                dec_o.code = CMD_PRE;
                                dec_o.bank = pins_i.ba;
                            end
                        end
                        default: dec_o.code = CMD_NOP;
                    endcase
                end
            end
            2'b10: begin
                if (!pins_i.cs_n && {pins_i.ras_n, pins_i.cas_n, pins_i.we_n} == 3'b001)
                    dec_o.code = CMD_SREF_IN;
                else if (quiet_pins)
                    dec_o.code = CMD_PD_IN;
                else
                    dec_o.code = CMD_NOP;
            end
            2'b01:   dec_o.code = in_sref_i ? CMD_SREF_OUT : CMD_PD_OUT;
            default: dec_o.code = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddrcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  dec_t                 dec_i,
    output logic [NUM_BANKS-1:0] open_o
);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = (dec_i.bank == BANK_W'(g));

        always_ff @(posedge clk) begin
            if (rst)
                open_o[g] <= 1'b0;
            else if (dec_i.code == CMD_ACT && hit)
                open_o[g] <= 1'b1;
            else if (dec_i.code == CMD_PREA || (closes_bank(dec_i.code) && hit))
                open_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/ddr_rule_check.sv
module ddr_rule_check
    import ddrcmd_pkg::*;
#(
    parameter int MRD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  cmd_e code_i,
    input  logic any_open_i,
    output logic err_o
);

    localparam int LOCK_W = (MRD_CYCLES < 2) ? 1 : $clog2(MRD_CYCLES);
    localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(MRD_CYCLES - 1);

    logic [LOCK_W-1:0] lock_q;
    logic              locked;
    logic              needs_idle;

    assign locked     = (lock_q != '0);
    assign needs_idle = is_mode_write(code_i) || is_refresh(code_i);
    assign err_o      = (locked && code_i != CMD_NOP) || (needs_idle && any_open_i);

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= '0;
        else if (is_mode_write(code_i))
            lock_q <= LOCK_LOAD;
        else if (locked)
            lock_q <= lock_q - 1'b1;
    end

endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
    import ddrcmd_pkg::*;
#(
    parameter int MRD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic              a10_i,
    output logic [3:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              err_o
);

    localparam int NUM_BANKS = 1 << BANK_W;

    pins_t                pins;
    dec_t                 dec;
    logic                 cke_q;
    logic                 sref_q;
    logic [NUM_BANKS-1:0] open_w;
    logic                 err_w;

    always_comb begin
        pins.cke   = cke_i;
        pins.cs_n  = cs_n_i;
        pins.ras_n = ras_n_i;
        pins.cas_n = cas_n_i;
        pins.we_n  = we_n_i;
        pins.ba    = ba_i;
        pins.a10   = a10_i;
    end

    ddr_cmd_classify u_cls (
        .pins_i     (pins),
        .cke_prev_i (cke_q),
        .in_sref_i  (sref_q),
        .dec_o      (dec)
    );

    ddr_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_trk (
        .clk    (clk),
        .rst    (rst),
        .dec_i  (dec),
        .open_o (open_w)
    );

    ddr_rule_check #(.MRD_CYCLES(MRD_CYCLES)) u_rule (
        .clk        (clk),
        .rst        (rst),
        .code_i     (dec.code),
        .any_open_i (|open_w),
        .err_o      (err_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q  <= 1'b1;
            sref_q <= 1'b0;
            cmd_o  <= 4'd0;
            bank_o <= '0;
            err_o  <= 1'b0;
        end else begin
            cke_q  <= cke_i;
            if (dec.code == CMD_SREF_IN)
                sref_q <= 1'b1;
            else if (dec.code == CMD_SREF_OUT)
                sref_q <= 1'b0;
            cmd_o  <= dec.code;
            bank_o <= dec.bank;
            err_o  <= err_w;
        end
    end

endmodule

// File: rtl/ddr_cmd_check.sv
module ddr_cmd_check (
    input logic       clk,
    input logic       rst,
    input logic [3:0] cmd,
    input logic [1:0] bank,
    input logic       err
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (cmd == 4'd0 && bank == 2'd0 && !err)); // R1

    AST_ERR_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
        err |-> (cmd != 4'd0)); // R12

    AST_MRS_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'd1 || cmd == 4'd2) |=> (cmd == 4'd0 || err)); // R11

    AST_NONBANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(cmd inside {4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12}) |-> (bank == 2'd0)); // R13

    AST_SREF_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'd4) |=> (cmd == 4'd0 || cmd == 4'd5)); // R8

    AST_PD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'd14) |=> (cmd == 4'd0 || cmd == 4'd15)); // R8

endmodule

bind ddr_cmd_decoder ddr_cmd_check u_chk (
    .clk  (clk),
    .rst  (rst),
    .cmd  (cmd_o),
    .bank (bank_o),
    .err  (err_o)
);

// File: tb/ddr_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module ddr_cmd_decoder_tb_top;

    localparam int MRD = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] cmd_o;
    logic [1:0] bank_o;
    logic       err_o;

    ddr_cmd_decoder #(.MRD_CYCLES(MRD)) dut_i (
        .clk(clk), .rst(rst), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .a10_i(a10),
        .cmd_o(cmd_o), .bank_o(bank_o), .err_o(err_o)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Bench model state, kept from the requirements.
    logic       m_cke;
    logic       m_sref;
    logic [3:0] m_open;
    int         m_lock;

    function automatic string req_of(int c);
        case (c)
            0:                return "R2";
            1, 2:             return "R3";
            3, 4:             return "R4";
            5, 14, 15:        return "R8";
            8, 10:            return "R6";
            13:               return "R7";
            default:          return "R5";
        endcase
    endfunction

    task automatic model_reset();
        m_cke = 1'b1; m_sref = 1'b0; m_open = 4'd0; m_lock = 0;
    endtask

    task automatic check(input string tag, input int ec, input int eb, input bit ee);
        n_vec++;
        if (cmd_o !== 4'(ec) || bank_o !== 2'(eb) || err_o !== ee) begin
            n_bad++;
            $display("FAIL %s: cmd %0d exp %0d, bank %0d exp %0d, err %0d exp %0d",
                     tag, cmd_o, ec, bank_o, eb, err_o, ee);
        end
    endtask

    task automatic drive(input logic k, input logic cs, input logic r, input logic c,
                         input logic w, input logic [1:0] b, input logic a, input string tag);
        int  ec, eb;
        bit  ee;
        logic quiet;
        @(negedge clk);
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = b; a10 = a;
        ec = 0; eb = 0;
        quiet = cs | (r & c & w);
        if (m_cke && k) begin
            if (!cs) case ({r, c, w})
                3'b000: ec = b[0] ? 2 : 1;
                3'b001: ec = 3;
                3'b011: begin ec = 6; eb = b; end
                3'b101: begin ec = a ? 8 : 7; eb = b; end
                3'b100: begin ec = a ? 10 : 9; eb = b; end
                3'b110: ec = 11;
                3'b010: begin if (a) ec = 13; else begin ec = 12; eb = b; end end
                default: ec = 0;
            endcase
        end else if (m_cke && !k) begin
            if (!cs && {r, c, w} == 3'b001) ec = 4;
            else if (quiet) ec = 14;
        end else if (!m_cke && k) begin
            ec = m_sref ? 5 : 15;
        end
        ee = (m_lock > 0 && ec != 0) || ((ec >= 1 && ec <= 4) && (m_open != 4'd0));
        if (ec == 1 || ec == 2) m_lock = MRD - 1;
        else if (m_lock > 0) m_lock--;
        if (ec == 6) m_open[eb] = 1'b1;
        if (ec == 12 || ec == 8 || ec == 10) m_open[eb] = 1'b0;
        if (ec == 13) m_open = 4'd0;
        if (ec == 4) m_sref = 1'b1;
        if (ec == 5) m_sref = 1'b0;
        m_cke = k;
        @(posedge clk);
        #1;
        check((tag == "") ? req_of(ec) : tag, ec, eb, ee);
    endtask

    // Shorthands with CKE held high.
    task automatic nop(input string t);             drive(1, 0, 1, 1, 1, 2'd0, 0, t); endtask
    task automatic mrs(input logic [1:0] b, input string t); drive(1, 0, 0, 0, 0, b, 0, t); endtask
    task automatic act(input logic [1:0] b, input string t); drive(1, 0, 0, 1, 1, b, 0, t); endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, exp completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset held", 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        check("R1 after release", 0, 0, 0);

        drive(1, 1, 0, 0, 0, 2'd3, 1, "R2 deselect");
        drive(1, 0, 1, 1, 1, 2'd2, 1, "R2 nop pins");
        mrs(2'd0, "R3 mrs legal");
        nop("R11 lock nop");
        mrs(2'd1, "R11 emrs two cycles later");
        act(2'd2, "R12 act in lockout");           // error and bank 2 opens
        mrs(2'd2, "R9 mrs with open bank");         // ba0=0 -> code 1
        nop("R11 nop after mrs");
        nop("R2 nop");
        drive(1, 0, 0, 0, 1, 2'd0, 0, "R10 refresh with open bank");
        drive(1, 0, 1, 0, 1, 2'd2, 1, "R6 read autoprecharge");
        drive(1, 0, 0, 0, 1, 2'd0, 0, "R4 refresh idle");
        act(2'd1, "R5 act b");
        act(2'd3, "R5 act d");
        drive(1, 0, 1, 0, 0, 2'd3, 0, "R5 write");
        drive(1, 0, 1, 0, 0, 2'd3, 1, "R6 write autoprecharge");
        drive(1, 0, 0, 1, 0, 2'd1, 0, "R5 precharge one");
        act(2'd0, "R5 act a");
        drive(1, 0, 0, 1, 0, 2'd3, 1, "R7 precharge all");
        drive(1, 0, 1, 1, 0, 2'd2, 0, "R13 burst stop");
        mrs(2'd0, "R9 mrs after precharge all");
        nop("R11 lock nop");
        drive(0, 0, 0, 0, 1, 2'd0, 0, "R4 self refresh entry");
        drive(0, 0, 0, 1, 1, 2'd1, 0, "R8 cke low held");
        drive(1, 1, 1, 1, 1, 2'd0, 0, "R8 self refresh exit");
        drive(0, 1, 1, 1, 1, 2'd0, 0, "R8 power down entry");
        drive(0, 0, 0, 0, 0, 2'd0, 0, "R8 cke low ignores pins");
        drive(1, 1, 1, 1, 1, 2'd0, 0, "R8 power down exit");
        drive(0, 0, 0, 1, 1, 2'd2, 0, "R8 cke fall with act");
        drive(1, 1, 1, 1, 1, 2'd0, 0, "R8 exit after plain fall");
        drive(1, 0, 0, 1, 0, 2'd0, 1, "R7 close all");

        for (int i = 0; i < 4000; i++) begin
            logic k;
            k = ($urandom_range(0, 15) == 0) ? ~m_cke : m_cke;
            if (!m_cke && $urandom_range(0, 3) == 0) k = 1'b1;
            drive(k, ($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom), 1'($urandom),
                  2'($urandom), 1'($urandom), "");
        end

        summary();
        $finish;
    end

endmodule